// File: doc/BRIEF.md
# Word Memory with Address/Data Registers

This block is a synchronous word memory that a client never touches directly. Every access is staged through two holding registers: an address register and a data register. The client first puts an address into the address register and, for a write, a value into the data register. It then raises a one-cycle fetch or store request. A small access sequencer carries the request out in one fixed access cycle. A fetch copies the addressed word into the data register. A store copies the data register into the addressed word.

The array holds 4096 words of 16 bits, addressed by a 12-bit unsigned value. A word is wide enough for a 4-bit operation code plus a 12-bit address. The address is split into a high part and a low part. Each part drives its own one-hot decoder, one for the row and one for the column, and the word sits where the selected row and the selected column meet.

Busy is high while an access is in flight, and done pulses when the access ends. The client may load both holding registers in the same cycle as the request, and those values are the ones the access uses.

Top module: `staged_word_mem`

## Requirements
- R1: After a synchronous reset, the address register, the data register, busy and done are all zero.
- R2: When `addr_load` is high at a clock edge, `addr_q` takes `addr_in`. When `data_load` is high and no fetch is completing, `data_q` takes `data_in`. Otherwise both registers hold their value.
- R3: A fetch request accepted while idle ends one edge after it was accepted. At that edge `data_q` takes the word stored at the address held in `addr_q` during the access cycle.
- R4: Every access takes the same number of cycles at every address. Busy is high for the one cycle after the accepting edge, and done is high for the cycle after that.
- R5: An accepted store writes the value that `data_q` holds during the access cycle into the word at `addr_q`. A later fetch of that address returns it.
- R6: Busy rises on the edge that accepts a request and falls on the next edge. Done is high for exactly one cycle, starting on the edge where busy falls.
- R7: A fetch or store request that arrives while busy is high is ignored. It produces no extra busy or done cycle, and it changes no stored word and no register.
- R8: If fetch and store are requested in the same idle cycle, a store is performed and `data_q` is not replaced by memory contents.
- R9: If a fetch completes on the same edge that `data_load` is high, the data register takes the memory word, not `data_in`.
- R10: The upper 6 address bits select the row and the lower 6 bits select the column. Addresses that differ only in row bits, or only in column bits, reach distinct words.
- R11: Register loads presented in the same cycle as an accepted request take effect on the accepting edge, so the access uses the newly loaded address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Load the address register from `addr_in` |
| addr_in | input | 12 | New address value |
| data_load | input | 1 | Load the data register from `data_in` |
| data_in | input | 16 | New data value |
| fetch_req | input | 1 | One-cycle read request |
| store_req | input | 1 | One-cycle write request |
| busy | output | 1 | Access in flight |
| done | output | 1 | One-cycle access-complete pulse |
| addr_q | output | 12 | Address register contents |
| data_q | output | 16 | Data register contents |

## Verification
A request sampled at edge E0 shows busy after E0. The fetched word and the done pulse appear after E1, and a stored word can be read back by the next accepted fetch. Register loads appear one edge after they are presented. The bench advances a behavioural model at every rising edge from the same inputs, then compares all four outputs one nanosecond later, so each result is checked in exactly the cycle it is due. Inputs change only on falling edges.

// File: rtl/swm_pkg.sv
package swm_pkg;

    localparam int ADDR_BITS = 12;
    localparam int WORD_BITS = 16;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_FETCH = 2'd1,
        ACC_STORE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic      active;
        acc_kind_e kind;
    } acc_slot_t;

    localparam acc_slot_t SLOT_IDLE = '{active: 1'b0, kind: ACC_NONE};

    function automatic acc_kind_e pick_kind(input logic fetch, input logic store);
        if (store)      return ACC_STORE;
        else if (fetch) return ACC_FETCH;
        else            return ACC_NONE;
    endfunction

endpackage

// File: rtl/swm_onehot_dec.sv
module swm_onehot_dec #(
    parameter int N = 6,
    localparam int LINES = 1 << N
) (
    input  logic [N-1:0]     code,
    output logic [LINES-1:0] lines
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign lines[i] = (code == N'(i));
    end
endmodule

// File: rtl/swm_sequencer.sv
module swm_sequencer
    import swm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fetch_req,
    input  logic store_req,
    output logic busy,
    output logic done,
    output logic mem_we,
    output logic fetch_fin
);
    acc_slot_t slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= SLOT_IDLE;
            done <= 1'b0;
        end else begin
            done <= slot.active;
            if (slot.active) begin
                slot <= SLOT_IDLE;
            end else if (fetch_req || store_req) begin
                slot.active <= 1'b1;
                slot.kind   <= pick_kind(fetch_req, store_req);
            end
        end
    end

    assign busy      = slot.active;
    assign mem_we    = slot.active && (slot.kind == ACC_STORE);
    assign fetch_fin = slot.active && (slot.kind == ACC_FETCH);

    assert_accept_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && (fetch_req || store_req)) |=> busy);
    assert_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy && done));
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && (fetch_req || store_req)) |=> !busy);
    assert_store_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && fetch_req && store_req) |=> (mem_we && !fetch_fin));

endmodule

// File: rtl/swm_cell_array.sv
module swm_cell_array #(
    parameter int ROW_BITS  = 6,
    parameter int COL_BITS  = 6,
    parameter int WORD_BITS = 16,
    localparam int ROWS = 1 << ROW_BITS,
    localparam int COLS = 1 << COL_BITS,
    localparam int ADDR_BITS = ROW_BITS + COL_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_BITS-1:0] addr,
    input  logic [WORD_BITS-1:0] wdata,
    output logic [WORD_BITS-1:0] rdata
);
    logic [ROWS-1:0]      row_sel;
    logic [COLS-1:0]      col_sel;
    logic [WORD_BITS-1:0] cells [ROWS][COLS];

    swm_onehot_dec #(.N(ROW_BITS)) u_row_dec (
        .code  (addr[ADDR_BITS-1:COL_BITS]),
        .lines (row_sel)
    );

    swm_onehot_dec #(.N(COL_BITS)) u_col_dec (
        .code  (addr[COL_BITS-1:0]),
        .lines (col_sel)
    );

    always_ff @(posedge clk) begin
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (wr_en && row_sel[r] && col_sel[c]) begin
                    cells[r][c] <= wdata;
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                rdata = rdata | (cells[r][c] & {WORD_BITS{row_sel[r] & col_sel[c]}});
            end
        end
    end

    assert_row_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $countones(row_sel) == 1);
    assert_col_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $countones(col_sel) == 1);

endmodule

// File: rtl/staged_word_mem.sv
module staged_word_mem
    import swm_pkg::*;
#(
    parameter int ADDR_W = ADDR_BITS,
    parameter int DATA_W = WORD_BITS,
    localparam int ROW_W = ADDR_W / 2,
    localparam int COL_W = ADDR_W - ROW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              data_load,
    input  logic [DATA_W-1:0] data_in,
    input  logic              fetch_req,
    input  logic              store_req,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);
    logic              mem_we;
    logic              fetch_fin;
    logic [DATA_W-1:0] rd_word;

    swm_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .fetch_req (fetch_req),
        .store_req (store_req),
        .busy      (busy),
        .done      (done),
        .mem_we    (mem_we),
        .fetch_fin (fetch_fin)
    );

    swm_cell_array #(
        .ROW_BITS  (ROW_W),
        .COL_BITS  (COL_W),
        .WORD_BITS (DATA_W)
    ) u_cells (
        .clk   (clk),
        .rst   (rst),
        .wr_en (mem_we),
        .addr  (addr_q),
        .wdata (data_q),
        .rdata (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (addr_load) begin
            addr_q <= addr_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (fetch_fin) begin
            data_q <= rd_word;
        end else if (data_load) begin
            data_q <= data_in;
        end
    end

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (addr_q == '0 && data_q == '0 && !busy && !done));
    assert_addr_load_R2: assert property (@(posedge clk) disable iff (rst)
        addr_load |=> (addr_q == $past(addr_in)));
    assert_data_load_R2: assert property (@(posedge clk) disable iff (rst)
        (data_load && !fetch_fin) |=> (data_q == $past(data_in)));
    assert_fetch_word_R3: assert property (@(posedge clk) disable iff (rst)
        fetch_fin |=> (data_q == $past(rd_word)));
    assert_store_keeps_data_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !data_load) |=> $stable(data_q));

endmodule

// File: tb/sim_staged_word_mem.sv
`timescale 1ns/1ps
module sim_staged_word_mem;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_load = 1'b0;
    logic [11:0] addr_in = '0;
    logic        data_load = 1'b0;
    logic [15:0] data_in = '0;
    logic        fetch_req = 1'b0;
    logic        store_req = 1'b0;
    logic        busy, done;
    logic [11:0] addr_q;
    logic [15:0] data_q;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";

    logic [15:0] ref_mem [4096];
    logic [11:0] m_addr = '0;
    logic [15:0] m_data = '0;
    logic        m_busy = 1'b0;
    logic        m_done = 1'b0;
    int          m_op = 0;

    always #2 clk = ~clk;

    staged_word_mem u0 (
        .clk(clk), .rst(rst), .addr_load(addr_load), .addr_in(addr_in),
        .data_load(data_load), .data_in(data_in), .fetch_req(fetch_req),
        .store_req(store_req), .busy(busy), .done(done),
        .addr_q(addr_q), .data_q(data_q)
    );

    always @(posedge clk) begin
        logic [11:0] n_addr;
        logic [15:0] n_data;
        logic        n_busy, n_done, fin_fetch;
        int          n_op;
        if (rst) begin
            n_addr = '0; n_data = '0; n_busy = 0; n_done = 0; n_op = 0;
        end else begin
            n_addr = addr_load ? addr_in : m_addr;
            fin_fetch = m_busy && m_op == 1;
            if (m_busy && m_op == 2) ref_mem[m_addr] = m_data;
            if (fin_fetch)      n_data = ref_mem[m_addr];
            else if (data_load) n_data = data_in;
            else                n_data = m_data;
            n_done = m_busy;
            n_busy = 0;
            n_op = 0;
            if (!m_busy && (fetch_req || store_req)) begin
                n_busy = 1;
                n_op = store_req ? 2 : 1;
            end
        end
        m_addr = n_addr; m_data = n_data; m_busy = n_busy; m_done = n_done; m_op = n_op;
        #1;
        checks++;
        if (addr_q !== m_addr || data_q !== m_data || busy !== m_busy || done !== m_done) begin
            errors++;
            $display("FAIL %s: got addr=%h data=%h busy=%b done=%b, expected addr=%h data=%h busy=%b done=%b",
                     cur_tag, addr_q, data_q, busy, done, m_addr, m_data, m_busy, m_done);
        end
    end

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic set_addr(input logic [11:0] a);
        @(negedge clk); addr_load = 1; addr_in = a;
        @(negedge clk); addr_load = 0;
    endtask

    task automatic set_data(input logic [15:0] d);
        @(negedge clk); data_load = 1; data_in = d;
        @(negedge clk); data_load = 0;
    endtask

    // Request cycle, busy cycle, then returns with done visible.
    task automatic request(input logic f, input logic s);
        @(negedge clk); fetch_req = f; store_req = s;
        @(negedge clk); fetch_req = 0; store_req = 0;
        @(negedge clk);
    endtask

    task automatic write_word(input logic [11:0] a, input logic [15:0] d);
        set_addr(a); set_data(d); request(0, 1);
    endtask

    task automatic read_word(input string tag, input logic [11:0] a, input logic [15:0] exp);
        set_addr(a); request(1, 0);
        chk(tag, data_q, exp);
        chk({tag, " done"}, 16'(done), 16'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        cur_tag = "R1";
        chk("R1 addr", 16'(addr_q), 16'h0);
        chk("R1 data", data_q, 16'h0);
        chk("R1 busy", 16'(busy), 16'h0);

        cur_tag = "R2";
        set_addr(12'hA5C); chk("R2 addr", 16'(addr_q), 16'h0A5C);
        set_data(16'h1234); chk("R2 data", data_q, 16'h1234);

        cur_tag = "R5";
        write_word(12'h000, 16'h1111);
        read_word("R5 R3 word0", 12'h000, 16'h1111);

        cur_tag = "R10";
        write_word(12'h041, 16'hA041);
        write_word(12'h040, 16'hA040);
        write_word(12'h001, 16'hA001);
        write_word(12'hFFF, 16'hAFFF);
        write_word(12'hFC0, 16'hAFC0);
        write_word(12'h03F, 16'hA03F);
        cur_tag = "R4";
        read_word("R10 41", 12'h041, 16'hA041);
        read_word("R10 40", 12'h040, 16'hA040);
        read_word("R10 01", 12'h001, 16'hA001);
        read_word("R4 FFF", 12'hFFF, 16'hAFFF);
        read_word("R10 FC0", 12'hFC0, 16'hAFC0);
        read_word("R10 03F", 12'h03F, 16'hA03F);
        read_word("R10 000", 12'h000, 16'h1111);

        cur_tag = "R11";
        @(negedge clk); addr_load = 1; addr_in = 12'h777; data_load = 1; data_in = 16'h7E7E; store_req = 1;
        @(negedge clk); addr_load = 0; data_load = 0; store_req = 0;
        chk("R11 busy", 16'(busy), 16'h1);
        @(negedge clk);
        @(negedge clk); data_load = 1; data_in = 16'h0000; addr_load = 1; addr_in = 12'h777; fetch_req = 1;
        @(negedge clk); data_load = 0; addr_load = 0; fetch_req = 0;
        @(negedge clk);
        chk("R11 fetch", data_q, 16'h7E7E);

        cur_tag = "R7";
        set_addr(12'h123); set_data(16'h0BAD);
        @(negedge clk); fetch_req = 1;
        @(negedge clk); fetch_req = 0; store_req = 1;
        @(negedge clk); store_req = 0;
        chk("R7 done", 16'(done), 16'h1);
        @(negedge clk);
        chk("R7 no extra", 16'(busy | done), 16'h0);
        read_word("R7 word kept", 12'h041, 16'hA041);

        cur_tag = "R8";
        set_addr(12'h200); set_data(16'h5A5A);
        request(1, 1);
        chk("R8 data kept", data_q, 16'h5A5A);
        set_data(16'h0000);
        read_word("R8 stored", 12'h200, 16'h5A5A);

        cur_tag = "R9";
        set_addr(12'hFFF);
        @(negedge clk); fetch_req = 1;
        @(negedge clk); fetch_req = 0; data_load = 1; data_in = 16'hBEEF;
        @(negedge clk); data_load = 0;
        chk("R9 memory wins", data_q, 16'hAFFF);

        cur_tag = "R6";
        request(1, 0);
        @(negedge clk);
        chk("R6 done fell", 16'(done), 16'h0);

        cur_tag = "R1";
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        chk("R1 rerst", data_q, 16'h0);
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule